// File: doc/BRIEF.md
# Subtract-and-Skip Accumulator Processor

This block is a small processor core with a single instruction. An instruction word carries no operation field: its low address bits name a memory word. Executing it subtracts the accumulator from that word, writes the difference into both the word and the accumulator, and arms a skip of the next instruction when the subtraction borrows. There is no program counter register. The program counter is memory word 0, so an instruction that names address 0 computes a jump. All other control flow is built from the borrow-driven skip.

The core runs a fixed six-cycle sequence per instruction against a synchronous single-port word memory. The program counter is read and fetched. The incremented counter is written back. The operand is then read, subtracted and written. A pending skip is applied when the counter is next read, so the memory port is never needed twice in one cycle. A level interrupt request is sampled at the end of each instruction. It sets a redirect flag, and while the flag is set every reference to word 0 lands on word 1. Any instruction that names the dedicated clear address drops the flag two cycles after its last memory access. The instruction that follows therefore reads its counter from word 1 and writes the incremented value to word 0, which is the return path.

Memory is loaded through a valid/ready preload port that accepts words only while reset is held. A debug group pulses once per completed instruction and shows the counter value, the operand address, the new accumulator and the skip flag.

Top module: `ssp_core`

## Requirements
- R1: Only the low 8 bits of an instruction word form the operand address; bits 15:8 are ignored.
- R2: Each instruction writes (mem[a] - acc) mod 2^16 into both mem[a] and the accumulator; the accumulator changes at no other time.
- R3: If mem[a] < acc (unsigned borrow), the skip flag is set and the next instruction in sequence is not executed; otherwise the skip flag is cleared.
- R4: Word 0 holds the program counter: each instruction writes counter+1 to word 0 before reading its operand, so an operand of 0 subtracts from the incremented counter, and the difference (plus 1 on borrow) is where execution continues.
- R5: Every instruction takes exactly 6 clock cycles, and dbg_done pulses for exactly one cycle per instruction, 6 cycles apart.
- R6: When irq is high in the last cycle of an instruction, the redirect flag is set, and from the next instruction on every memory reference to address 0 (counter read, counter write, fetch, operand) goes to address 1.
- R7: An instruction whose operand address is 255 clears the redirect flag 2 cycles after its final memory write: the following instruction still reads its counter from word 1, but all its later references to address 0 go to word 0. If irq is high at the end of that same instruction, the flag stays set.
- R8: Reset clears the accumulator, the skip flag and the redirect flag, and keeps dbg_done low; the first instruction after reset fetches from the address held in preloaded word 0.
- R9: pl_ready is high exactly while rst is high; a word is written when pl_valid and pl_ready are both high, and pl_valid while pl_ready is low writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; preload window |
| irq | input | 1 | Interrupt request level, sampled at the end of each instruction |
| pl_valid | input | 1 | Preload word offered |
| pl_ready | output | 1 | Preload word accepted (high only during reset) |
| pl_addr | input | 8 | Preload target word address |
| pl_data | input | 16 | Preload word value |
| dbg_done | output | 1 | One-cycle pulse after each completed instruction |
| dbg_pc | output | 16 | Counter value the completed instruction was fetched from |
| dbg_opa | output | 8 | Operand address of the completed instruction |
| dbg_acc | output | 16 | Accumulator after the completed instruction |
| dbg_skip | output | 1 | Skip flag after the completed instruction |

## Verification
The first dbg_done rises six clock cycles after reset is released, and each later one follows the previous pulse by exactly six cycles. The counter, operand address, accumulator and skip flag are all valid in the pulse cycle. The bench samples them at the falling edge during the pulse and also measures the gap between pulses. The interrupt request only matters in the last cycle of an instruction, so the bench changes irq in the first cycle of an instruction (the pulse cycle of the previous one) and holds it for the whole instruction. Its reference model then sets the flag at the same instruction boundary and applies the two-cycle clear at the next counter read.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Phases of one instruction, executed in this order
  typedef enum logic [2:0] {
    ST_PCRD  = 3'd0,  // read counter word
    ST_FETCH = 3'd1,  // fetch instruction at counter (+ pending skip)
    ST_PCWR  = 3'd2,  // write counter+1 back
    ST_OPRD  = 3'd3,  // read operand word
    ST_SUB   = 3'd4,  // subtract, latch borrow
    ST_WB    = 3'd5   // write difference to operand and accumulator
  } ssp_state_e;

  localparam int unsigned SSP_PHASES = 6;

endpackage

// File: rtl/ssp_mem.sv
module ssp_mem #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          pl_wr,
  input  logic [AW-1:0] pl_addr,
  input  logic [DW-1:0] pl_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  // Preload has priority; the core is held in reset while it is used
  always_ff @(posedge clk) begin
    if (pl_wr) begin
      store[pl_addr] <= pl_data;
    end else if (en && we) begin
      store[addr] <= wdata;
    end
  end

  // Registered read: data appears one cycle after the address
  always_ff @(posedge clk) begin
    if (en) begin
      rdata <= store[addr];
    end
  end

endmodule

// File: rtl/ssp_sub.sv
module ssp_sub #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] minuend,
  input  logic [DW-1:0] subtrahend,
  output logic [DW-1:0] diff,
  output logic          borrow
);
  logic [DW:0] bchain;

  assign bchain[0] = 1'b0;

  // Ripple borrow chain, one full subtractor per bit
  for (genvar g = 0; g < DW; g++) begin : g_bit
    assign diff[g]       = minuend[g] ^ subtrahend[g] ^ bchain[g];
    assign bchain[g + 1] = (~minuend[g] & subtrahend[g]) |
                           (~(minuend[g] ^ subtrahend[g]) & bchain[g]);
  end

  assign borrow = bchain[DW];

endmodule

// File: rtl/ssp_irq.sv
module ssp_irq #(
  parameter int unsigned AW       = 8,
  parameter int unsigned CLR_ADDR = 255
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_req,
  input  logic          instr_end,   // last cycle of an instruction
  input  logic          pc_phase,    // counter-read cycle
  input  logic [AW-1:0] instr_opa,   // operand address of current instruction
  input  logic [AW-1:0] addr_raw,
  output logic [AW-1:0] addr_eff,
  output logic          flag
);
  localparam logic [AW-1:0] CLR_A = AW'(CLR_ADDR);

  logic clr_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag     <= 1'b0;
      clr_pend <= 1'b0;
    end else if (instr_end) begin
      if (irq_req) begin
        flag     <= 1'b1;
        clr_pend <= 1'b0;
      end else if (instr_opa == CLR_A) begin
        clr_pend <= 1'b1;
      end
    end else if (pc_phase && clr_pend) begin
      flag     <= 1'b0;
      clr_pend <= 1'b0;
    end
  end

  // References to word 0 fold onto word 1 while the flag is set
  always_comb begin
    addr_eff    = addr_raw;
    addr_eff[0] = addr_raw[0] | (flag && (addr_raw == '0));
  end

  p_flag_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(instr_end && irq_req));

  p_flag_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(pc_phase));

endmodule

// File: rtl/ssp_seq.sv
module ssp_seq
  import ssp_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] addr_raw,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] sub_min,
  output logic [DW-1:0] sub_sub,
  input  logic [DW-1:0] sub_diff,
  input  logic          sub_borrow,
  output logic          instr_end,
  output logic          pc_phase,
  output logic [AW-1:0] opa_o,
  output logic          dbg_done,
  output logic [DW-1:0] dbg_pc,
  output logic [AW-1:0] dbg_opa,
  output logic [DW-1:0] dbg_acc,
  output logic          dbg_skip
);
  ssp_state_e    st_q, st_d;
  logic [DW-1:0] pc_q, acc_q, diff_q, pc_next;
  logic [AW-1:0] opa_q;
  logic          skip_q, borrow_q;

  // Pending skip is folded into the counter as it is read
  assign pc_next = mem_rdata + {{(DW-1){1'b0}}, skip_q};

  always_comb begin
    case (st_q)
      ST_PCRD:  st_d = ST_FETCH;
      ST_FETCH: st_d = ST_PCWR;
      ST_PCWR:  st_d = ST_OPRD;
      ST_OPRD:  st_d = ST_SUB;
      ST_SUB:   st_d = ST_WB;
      default:  st_d = ST_PCRD;
    endcase
  end

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    addr_raw  = '0;
    mem_wdata = '0;
    case (st_q)
      ST_PCRD: begin
        mem_en = 1'b1;
      end
      ST_FETCH: begin
        mem_en   = 1'b1;
        addr_raw = pc_next[AW-1:0];
      end
      ST_PCWR: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = pc_q + 1'b1;
      end
      ST_OPRD: begin
        mem_en   = 1'b1;
        addr_raw = opa_q;
      end
      ST_WB: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        addr_raw  = opa_q;
        mem_wdata = diff_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_PCRD;
      pc_q     <= '0;
      opa_q    <= '0;
      diff_q   <= '0;
      borrow_q <= 1'b0;
      acc_q    <= '0;
      skip_q   <= 1'b0;
      dbg_done <= 1'b0;
    end else begin
      st_q     <= st_d;
      dbg_done <= (st_q == ST_WB);
      case (st_q)
        ST_FETCH: pc_q  <= pc_next;
        ST_PCWR:  opa_q <= mem_rdata[AW-1:0];
        ST_SUB: begin
          diff_q   <= sub_diff;
          borrow_q <= sub_borrow;
        end
        ST_WB: begin
          acc_q  <= diff_q;
          skip_q <= borrow_q;
        end
        default: ;
      endcase
    end
  end

  assign sub_min   = mem_rdata;
  assign sub_sub   = acc_q;
  assign instr_end = (st_q == ST_WB);
  assign pc_phase  = (st_q == ST_PCRD);
  assign opa_o     = opa_q;
  assign dbg_pc    = pc_q;
  assign dbg_opa   = opa_q;
  assign dbg_acc   = acc_q;
  assign dbg_skip  = skip_q;

  // Checker state: cycles since the previous completion pulse
  logic [3:0] gap_q;
  logic       seen_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (dbg_done) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != 4'hF) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  p_acc_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_WB) |=> $stable(acc_q));

  p_skip_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_WB) |=> $stable(skip_q));

  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    dbg_done |=> !dbg_done);

  p_done_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (dbg_done && seen_q) |-> (gap_q == 4'(SSP_PHASES - 1)));

endmodule

// File: rtl/ssp_core.sv
module ssp_core #(
  parameter int unsigned DW       = 16,
  parameter int unsigned AW       = 8,
  parameter int unsigned CLR_ADDR = 255
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq,
  input  logic          pl_valid,
  output logic          pl_ready,
  input  logic [AW-1:0] pl_addr,
  input  logic [DW-1:0] pl_data,
  output logic          dbg_done,
  output logic [DW-1:0] dbg_pc,
  output logic [AW-1:0] dbg_opa,
  output logic [DW-1:0] dbg_acc,
  output logic          dbg_skip
);
  logic          mem_en, mem_we, instr_end, pc_phase, irq_flag, sub_borrow;
  logic [AW-1:0] addr_raw, mem_addr, opa;
  logic [DW-1:0] mem_wdata, mem_rdata, sub_min, sub_sub, sub_diff;

  assign pl_ready = rst;

  ssp_seq #(.DW(DW), .AW(AW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .addr_raw   (addr_raw),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .sub_min    (sub_min),
    .sub_sub    (sub_sub),
    .sub_diff   (sub_diff),
    .sub_borrow (sub_borrow),
    .instr_end  (instr_end),
    .pc_phase   (pc_phase),
    .opa_o      (opa),
    .dbg_done   (dbg_done),
    .dbg_pc     (dbg_pc),
    .dbg_opa    (dbg_opa),
    .dbg_acc    (dbg_acc),
    .dbg_skip   (dbg_skip)
  );

  ssp_sub #(.DW(DW)) u_sub (
    .minuend    (sub_min),
    .subtrahend (sub_sub),
    .diff       (sub_diff),
    .borrow     (sub_borrow)
  );

  ssp_irq #(.AW(AW), .CLR_ADDR(CLR_ADDR)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .irq_req   (irq),
    .instr_end (instr_end),
    .pc_phase  (pc_phase),
    .instr_opa (opa),
    .addr_raw  (addr_raw),
    .addr_eff  (mem_addr),
    .flag      (irq_flag)
  );

  ssp_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk     (clk),
    .en      (mem_en),
    .we      (mem_we),
    .addr    (mem_addr),
    .wdata   (mem_wdata),
    .rdata   (mem_rdata),
    .pl_wr   (pl_valid && pl_ready),
    .pl_addr (pl_addr),
    .pl_data (pl_data)
  );

  p_no_zero_wr_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we && irq_flag) |-> (mem_addr != '0));

endmodule

// File: tb/ssp_core_bench.sv
module ssp_core_bench;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int DEPTH = 256;
  localparam logic [7:0] CLR = 8'hFF;

  typedef struct packed {
    logic [15:0] pc;
    logic [7:0]  opa;
    logic [15:0] acc;
    logic        skip;
    logic        irqctx;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq = 1'b0;
  logic pl_valid = 1'b0;
  logic pl_ready;
  logic [7:0] pl_addr = '0;
  logic [15:0] pl_data = '0;
  logic dbg_done, dbg_skip;
  logic [15:0] dbg_pc, dbg_acc;
  logic [7:0] dbg_opa;

  always #5 clk = ~clk;

  ssp_core #(.DW(DW), .AW(AW), .CLR_ADDR(255)) u_ssp_core (
    .clk(clk), .rst(rst), .irq(irq),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_addr(pl_addr), .pl_data(pl_data),
    .dbg_done(dbg_done), .dbg_pc(dbg_pc), .dbg_opa(dbg_opa),
    .dbg_acc(dbg_acc), .dbg_skip(dbg_skip)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference model state
  logic [15:0] m [DEPTH];
  logic [15:0] init_m [DEPTH];
  logic [15:0] acc_m;
  logic skip_m, flag_m, pend_m;
  bit irq_plan [512];
  int poke_idx = -1;
  exp_t q[$];
  bit running = 1'b0;
  int idx = 0;
  int last_done = -1;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] eff(input logic [7:0] a, input logic f);
    return (a == 8'd0 && f) ? 8'd1 : a;
  endfunction

  function automatic logic [15:0] rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr;
  endfunction

  // One instruction of the reference model, from the requirements
  task automatic model_step(input int k, output exp_t e);
    logic [15:0] pc, ins, v, d;
    logic [7:0] a, ea;
    logic fs0, fr;
    fs0 = flag_m;
    if (pend_m) begin flag_m = 1'b0; pend_m = 1'b0; end   // R7 two-cycle clear
    fr = flag_m;
    pc = m[fs0 ? 8'd1 : 8'd0] + {15'd0, skip_m};           // R3 skip, R6 redirect
    ins = m[eff(pc[7:0], fr)];
    m[eff(8'd0, fr)] = pc + 16'd1;                         // R4
    a = ins[7:0];                                          // R1
    ea = eff(a, fr);
    v = m[ea];
    d = v - acc_m;                                         // R2
    skip_m = (v < acc_m);                                  // R3
    m[ea] = d;
    acc_m = d;
    e.irqctx = fs0 | fr;
    if (irq_plan[k]) begin flag_m = 1'b1; pend_m = 1'b0; end
    else if (a == CLR) pend_m = 1'b1;
    e.pc = pc; e.opa = a; e.acc = acc_m; e.skip = skip_m;
  endtask

  task automatic run(input int n);
    exp_t e;
    rst = 1'b1;
    pl_valid = 1'b0;
    irq = irq_plan[0];
    acc_m = '0; skip_m = 1'b0; flag_m = 1'b0; pend_m = 1'b0;
    for (int i = 0; i < DEPTH; i++) m[i] = init_m[i];
    @(negedge clk);
    @(negedge clk);
    check(dbg_done == 1'b0, "R8 done low in reset", 32'(dbg_done), 0);
    check(dbg_acc == 16'd0, "R8 acc cleared", 32'(dbg_acc), 0);
    check(pl_ready == 1'b1, "R9 ready during reset", 32'(pl_ready), 1);
    for (int i = 0; i < DEPTH; i++) begin
      pl_valid = 1'b1; pl_addr = 8'(i); pl_data = init_m[i];
      @(negedge clk);
    end
    pl_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      model_step(k, e);
      q.push_back(e);
    end
    idx = 0;
    last_done = -1;
    running = 1'b1;
    rst = 1'b0;
    #1;
    check(pl_ready == 1'b0, "R9 ready low out of reset", 32'(pl_ready), 0);
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    running = 1'b0;
    pl_valid = 1'b0;
    irq = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (running && dbg_done) begin
      if (q.size() == 0) begin
        check(1'b0, "R5 extra completion", 32'(idx), 32'(-1));
      end else begin
        e = q.pop_front();
        check(dbg_opa == e.opa, "R1 operand address", 32'(dbg_opa), 32'(e.opa));
        check(dbg_acc == e.acc, "R2 accumulator", 32'(dbg_acc), 32'(e.acc));
        check(dbg_skip == e.skip, "R3 skip flag", 32'(dbg_skip), 32'(e.skip));
        if (e.irqctx)
          check(dbg_pc == e.pc, "R6 R7 counter under redirect", 32'(dbg_pc), 32'(e.pc));
        else if (idx == 0)
          check(dbg_pc == e.pc, "R8 first fetch from word 0", 32'(dbg_pc), 32'(e.pc));
        else
          check(dbg_pc == e.pc, "R4 counter word", 32'(dbg_pc), 32'(e.pc));
        if (last_done >= 0)
          check(cyc - last_done == 6, "R5 instruction length", 32'(cyc - last_done), 6);
        last_done = cyc;
        idx++;
        irq = irq_plan[idx];
        // R9: offer a destructive preload while running; must be ignored
        if (idx == poke_idx) begin
          pl_valid = 1'b1; pl_addr = 8'd0; pl_data = 16'h0000;
        end else begin
          pl_valid = 1'b0;
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) irq_plan[i] = 1'b0;

    // Directed: upper bits ignored (R1), clear sequence, jump through word 0 (R4)
    for (int i = 0; i < DEPTH; i++) init_m[i] = 16'd0;
    init_m[0] = 16'd16;
    init_m[16] = 16'hAB64; init_m[17] = 16'd101; init_m[18] = 16'd102;
    init_m[19] = 16'd100;  init_m[20] = 16'd100; init_m[21] = 16'd100;
    init_m[22] = 16'h7700; init_m[23] = 16'd102;
    init_m[100] = 16'd9; init_m[101] = 16'd3; init_m[102] = 16'd7;
    run(16);

    // Random memory, no interrupts, preload attempt mid-run (R9)
    for (int i = 0; i < DEPTH; i++) init_m[i] = rnd();
    init_m[0] = 16'd40;
    poke_idx = 50;
    run(400);
    poke_idx = -1;

    // Interrupts: entry via word 1, return through clear address (R6, R7)
    for (int i = 0; i < DEPTH; i++) init_m[i] = rnd();
    init_m[0] = 16'd30;
    init_m[1] = 16'd200;
    init_m[200] = 16'h00FF;
    init_m[201] = 16'd120;
    irq_plan[4] = 1'b1;
    for (int i = 60; i < 70; i++) irq_plan[i] = 1'b1;
    irq_plan[150] = 1'b1;
    irq_plan[151] = 1'b1;
    run(300);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      if (cyc >= 150000 && !finished) begin
        fails++;
        checks++;
        $display("FAIL watchdog R5 actual=%0d expected=<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

endmodule